// File: doc/BRIEF.md
# PCI Interrupt Swizzle and Line Router

This block collects interrupt requests from a set of PCI devices and turns them into a vector of level-sensitive inputs for an interrupt controller. Each requester supplies its device/function code, the interrupt pin it asserts (0 to 3, for INTA to INTD) and a level. The block reads the slot number from the code and converts the device pin into one of four bridge pins. Some on-board slots are tied to a fixed bridge pin. A group of add-in slots rotates the pin by its position in the group. Every other slot keeps the pin it has.

Each bridge pin has its own programmable routing byte. A byte below the line count selects one controller line. Any larger byte leaves the pin unconnected. A controller line is high while any bridge pin routed to it is high, so several pins and several devices can share one line. The line vector is registered and recomputed on every clock from the present levels and routing bytes. A small write port with combinational readback sets the routing bytes.

Top module: `irq_swizzle_router`

## Requirements
- R1: The slot number is the device/function code shifted right by three bits, so the low three function bits never affect which bridge pin is chosen.
- R2: A device in slot 10 drives bridge pin 3 whatever device pin it asserts.
- R3: A device in slot 11 or slot 12 drives bridge pin 0 whatever device pin it asserts.
- R4: A device in slots 18 to 21 drives bridge pin ((slot - 18) + device pin) mod 4.
- R5: A device in any other slot drives the bridge pin equal to its device pin.
- R6: Routing byte k belongs to bridge pin k. A value from 0 to 15 connects the pin to that controller line, so value 15 reaches line 15. A value of 16 or more disconnects the pin, and the pin then raises no line.
- R7: A controller line is the OR of all bridge pins routed to it, and a bridge pin is the OR of all active devices that map to it.
- R8: While reset is held, all four routing bytes read 0x80 and the line vector is zero.
- R9: A write with cfg_we high stores cfg_wdata into routing byte cfg_sel at the clock edge. cfg_rdata shows byte cfg_sel combinationally.
- R10: The line vector is registered. A change in device levels shows at line_q after exactly one rising clock edge. A routing write shows one edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dev_devfn | input | NUM_DEV*8 | Device/function code per requester, requester 0 in the low byte |
| dev_pin | input | NUM_DEV*2 | Device interrupt pin per requester (0 = INTA ... 3 = INTD) |
| dev_level | input | NUM_DEV | Request level per requester |
| cfg_we | input | 1 | Routing byte write strobe |
| cfg_sel | input | 2 | Routing byte index (bridge pin) |
| cfg_wdata | input | 8 | Routing byte write value |
| cfg_rdata | output | 8 | Routing byte selected by cfg_sel |
| line_q | output | NUM_LINES | Registered controller line levels |

## Verification
A change in device level is due at line_q one rising edge after it is applied. The bench drives inputs on the falling edge and samples on the next falling edge. It also samples just after the drive, before that edge, to show the output has not yet moved. A routing write lands on its own edge and shows on line_q one edge later, so each write is followed by one extra idle cycle before the check. Readback is combinational, so it is sampled a moment after cfg_sel is set.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
   // widths of the device/function code fields
   localparam int FUNC_BITS  = 3;
   // reset value of every routing byte: pin disconnected
   localparam logic [7:0] ROUTE_OFF = 8'h80;
endpackage

// File: rtl/irq_slot_swizzle.sv
module irq_slot_swizzle
   import irq_router_pkg::*;
#(
   parameter int DEVFN_W   = 8,
   parameter int NUM_PINS  = 4,
   parameter int FIXA_SLOT = 10,
   parameter int FIXA_PIN  = 3,
   parameter int FIXB_LO   = 11,
   parameter int FIXB_HI   = 12,
   parameter int FIXB_PIN  = 0,
   parameter int ROT_BASE  = 18,
   localparam int PIN_W    = $clog2(NUM_PINS),
   localparam int SLOT_W   = DEVFN_W - FUNC_BITS
) (
   input  logic [DEVFN_W-1:0] devfn,
   input  logic [PIN_W-1:0]   pin_in,
   output logic [PIN_W-1:0]   pin_out
);
   logic [SLOT_W-1:0] slot;
   int                slot_i;

   always_comb begin
      slot   = devfn[DEVFN_W-1:FUNC_BITS];
      slot_i = int'(slot);
      if (slot_i == FIXA_SLOT)
         pin_out = PIN_W'(FIXA_PIN);
      else if (slot_i >= FIXB_LO && slot_i <= FIXB_HI)
         pin_out = PIN_W'(FIXB_PIN);
      else if (slot_i >= ROT_BASE && slot_i < ROT_BASE + NUM_PINS)
         pin_out = PIN_W'(slot_i - ROT_BASE) + pin_in;
      else
         pin_out = pin_in;
   end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
   import irq_router_pkg::*;
#(
   parameter int NUM_PINS = 4,
   parameter int ROUTE_W  = 8,
   localparam int SEL_W   = $clog2(NUM_PINS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [SEL_W-1:0]             sel,
   input  logic [ROUTE_W-1:0]           wdata,
   output logic [ROUTE_W-1:0]           rdata,
   output logic [NUM_PINS*ROUTE_W-1:0]  route_flat
);
   logic [ROUTE_W-1:0] route_q [NUM_PINS];

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            route_q[p] <= ROUTE_W'(ROUTE_OFF);
         else if (we && sel == SEL_W'(p))
            route_q[p] <= wdata;
      end
      assign route_flat[p*ROUTE_W +: ROUTE_W] = route_q[p];
   end

   assign rdata = route_q[sel];
endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge #(
   parameter int NUM_PINS  = 4,
   parameter int NUM_LINES = 16,
   parameter int ROUTE_W   = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_PINS-1:0]          pin_lvl,
   input  logic [NUM_PINS*ROUTE_W-1:0]  route_flat,
   output logic [NUM_LINES-1:0]         line_q
);
   logic [NUM_LINES-1:0] line_d;

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      always_comb begin
         line_d[l] = 1'b0;
         for (int p = 0; p < NUM_PINS; p++) begin
            if (pin_lvl[p] && route_flat[p*ROUTE_W +: ROUTE_W] == ROUTE_W'(l))
               line_d[l] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= '0;
      else        line_q <= line_d;
   end
endmodule

// File: rtl/irq_swizzle_router.sv
module irq_swizzle_router
   import irq_router_pkg::*;
#(
   parameter int NUM_DEV   = 4,
   parameter int NUM_PINS  = 4,
   parameter int NUM_LINES = 16,
   parameter int DEVFN_W   = 8,
   parameter int ROUTE_W   = 8,
   localparam int PIN_W    = $clog2(NUM_PINS),
   localparam int SEL_W    = $clog2(NUM_PINS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_DEV*DEVFN_W-1:0] dev_devfn,
   input  logic [NUM_DEV*PIN_W-1:0]   dev_pin,
   input  logic [NUM_DEV-1:0]         dev_level,
   input  logic                       cfg_we,
   input  logic [SEL_W-1:0]           cfg_sel,
   input  logic [ROUTE_W-1:0]         cfg_wdata,
   output logic [ROUTE_W-1:0]         cfg_rdata,
   output logic [NUM_LINES-1:0]       line_q
);
   if (NUM_PINS != (1 << PIN_W)) begin : g_chk_pins
      $error("NUM_PINS must be a power of two for the rotation");
   end
   if (NUM_LINES > (1 << ROUTE_W)) begin : g_chk_lines
      $error("NUM_LINES exceeds what a routing byte can select");
   end
   if (DEVFN_W <= FUNC_BITS) begin : g_chk_devfn
      $error("DEVFN_W leaves no slot field");
   end

   logic [PIN_W-1:0]            bridge_pin [NUM_DEV];
   logic [NUM_PINS-1:0]         bridge_lvl;
   logic [NUM_PINS*ROUTE_W-1:0] route_flat;

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      irq_slot_swizzle #(
         .DEVFN_W  (DEVFN_W),
         .NUM_PINS (NUM_PINS)
      ) u_swz (
         .devfn   (dev_devfn[d*DEVFN_W +: DEVFN_W]),
         .pin_in  (dev_pin[d*PIN_W +: PIN_W]),
         .pin_out (bridge_pin[d])
      );
   end

   always_comb begin
      bridge_lvl = '0;
      for (int d = 0; d < NUM_DEV; d++) begin
         for (int p = 0; p < NUM_PINS; p++) begin
            if (dev_level[d] && bridge_pin[d] == PIN_W'(p))
               bridge_lvl[p] = 1'b1;
         end
      end
   end

   irq_route_regs #(
      .NUM_PINS (NUM_PINS),
      .ROUTE_W  (ROUTE_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (cfg_we),
      .sel        (cfg_sel),
      .wdata      (cfg_wdata),
      .rdata      (cfg_rdata),
      .route_flat (route_flat)
   );

   irq_line_merge #(
      .NUM_PINS  (NUM_PINS),
      .NUM_LINES (NUM_LINES),
      .ROUTE_W   (ROUTE_W)
   ) u_merge (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_lvl    (bridge_lvl),
      .route_flat (route_flat),
      .line_q     (line_q)
   );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
   parameter int NUM_PINS  = 4,
   parameter int NUM_LINES = 16,
   parameter int ROUTE_W   = 8,
   localparam int SEL_W    = $clog2(NUM_PINS),
   localparam int LINE_W   = $clog2(NUM_LINES)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NUM_PINS-1:0]         bridge_lvl,
   input logic [NUM_PINS*ROUTE_W-1:0] route_flat,
   input logic                        cfg_we,
   input logic [SEL_W-1:0]            cfg_sel,
   input logic [ROUTE_W-1:0]          cfg_wdata,
   input logic [NUM_LINES-1:0]        line_q
);
   // R6: each pin reaches at most one line
   p_line_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(line_q) <= NUM_PINS);

   // R10 / R7: no active bridge pin means all lines low one edge later
   p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bridge_lvl == '0) |=> (line_q == '0));

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      // R7: an active, routed pin raises its line on the next edge
      p_routed_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (bridge_lvl[p] && route_flat[p*ROUTE_W +: ROUTE_W] < ROUTE_W'(NUM_LINES))
         |=> line_q[$past(route_flat[p*ROUTE_W +: LINE_W])]);

      // R9: a write lands in the selected byte
      p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && cfg_sel == SEL_W'(p))
         |=> (route_flat[p*ROUTE_W +: ROUTE_W] == $past(cfg_wdata)));
   end
endmodule

bind irq_swizzle_router irq_router_chk #(
   .NUM_PINS  (NUM_PINS),
   .NUM_LINES (NUM_LINES),
   .ROUTE_W   (ROUTE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bridge_lvl (bridge_lvl),
   .route_flat (route_flat),
   .cfg_we     (cfg_we),
   .cfg_sel    (cfg_sel),
   .cfg_wdata  (cfg_wdata),
   .line_q     (line_q)
);

// File: tb/tb_irq_swizzle_router.sv
`timescale 1ns/1ps
module tb_irq_swizzle_router;
   localparam int NUM_DEV = 4;
   localparam int NLINE   = 16;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [NUM_DEV*8-1:0] dev_devfn = '0;
   logic [NUM_DEV*2-1:0] dev_pin = '0;
   logic [NUM_DEV-1:0]   dev_level = '0;
   logic                 cfg_we = 1'b0;
   logic [1:0]           cfg_sel = '0;
   logic [7:0]           cfg_wdata = '0;
   logic [7:0]           cfg_rdata;
   logic [NLINE-1:0]     line_q;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   irq_swizzle_router dut (
      .clk(clk), .rst_n(rst_n), .dev_devfn(dev_devfn), .dev_pin(dev_pin),
      .dev_level(dev_level), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .line_q(line_q));

   // {devfn0, pin0, lvl0, devfn1, pin1, lvl1, expected lines}
   // routes in force: pin0->5, pin1->9, pin2->5, pin3->14
   localparam int NV = 13;
   localparam logic [37:0] VEC [NV] = '{
      {8'h50, 2'd0, 1'b1, 8'h00, 2'd0, 1'b0, 16'h4000}, // R2 slot10 INTA
      {8'h52, 2'd2, 1'b1, 8'h00, 2'd0, 1'b0, 16'h4000}, // R2 R1 func bits
      {8'h58, 2'd3, 1'b1, 8'h00, 2'd0, 1'b0, 16'h0020}, // R3 slot11
      {8'h60, 2'd1, 1'b1, 8'h00, 2'd0, 1'b0, 16'h0020}, // R3 slot12
      {8'h90, 2'd1, 1'b1, 8'h00, 2'd0, 1'b0, 16'h0200}, // R4 slot18
      {8'h98, 2'd3, 1'b1, 8'h00, 2'd0, 1'b0, 16'h0020}, // R4 slot19 wrap
      {8'hA8, 2'd3, 1'b1, 8'h00, 2'd0, 1'b0, 16'h0020}, // R4 slot21
      {8'hA7, 2'd3, 1'b1, 8'h00, 2'd0, 1'b0, 16'h0200}, // R4 R1 slot20 func7
      {8'h88, 2'd1, 1'b1, 8'h00, 2'd0, 1'b0, 16'h0200}, // R5 slot17
      {8'hB0, 2'd3, 1'b1, 8'h00, 2'd0, 1'b0, 16'h4000}, // R5 slot22
      {8'h28, 2'd0, 1'b0, 8'h00, 2'd0, 1'b0, 16'h0000}, // R7 inactive
      {8'h28, 2'd0, 1'b1, 8'h29, 2'd2, 1'b1, 16'h0020}, // R7 shared line
      {8'h90, 2'd1, 1'b1, 8'h50, 2'd0, 1'b1, 16'h4200}  // R7 two lines
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic drive(input logic [7:0] f0, input logic [1:0] p0, input logic l0,
                        input logic [7:0] f1, input logic [1:0] p1, input logic l1);
      dev_devfn = {16'h0, f1, f0};
      dev_pin   = {4'h0, p1, p0};
      dev_level = {2'b00, l1, l0};
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // R8: reset state
      drive(8'h50, 2'd0, 1'b1, 8'h00, 2'd0, 1'b0);
      repeat (3) @(negedge clk);
      for (int s = 0; s < 4; s++) begin
         cfg_sel = 2'(s); #1;
         check("R8 reset byte", 32'(cfg_rdata), 32'h80);
      end
      check("R8 reset lines", 32'(line_q), 32'h0);
      rst_n = 1'b1;
      tick(); tick();
      // R6: bytes of 0x80 leave every pin disconnected
      check("R6 unrouted", 32'(line_q), 32'h0);

      // R9: program routes and read back
      wr(2'd0, 8'd5); wr(2'd1, 8'd9); wr(2'd2, 8'd5); wr(2'd3, 8'd14);
      cfg_sel = 2'd1; #1; check("R9 readback 1", 32'(cfg_rdata), 32'd9);
      cfg_sel = 2'd3; #1; check("R9 readback 3", 32'(cfg_rdata), 32'd14);
      tick();
      check("R9 R2 routed slot10", 32'(line_q), 32'h4000);

      // vector table (R1 R2 R3 R4 R5 R7)
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VEC[i][37:30], VEC[i][29:28], VEC[i][27],
               VEC[i][26:19], VEC[i][18:17], VEC[i][16]);
         @(negedge clk);
         check($sformatf("R1..R7 vector %0d", i), 32'(line_q), 32'(VEC[i][15:0]));
      end

      // R10: one-edge latency
      @(negedge clk); drive(8'h00, 2'd0, 1'b0, 8'h00, 2'd0, 1'b0);
      @(negedge clk); check("R10 idle", 32'(line_q), 32'h0);
      drive(8'h90, 2'd1, 1'b1, 8'h00, 2'd0, 1'b0);
      #1; check("R10 not before edge", 32'(line_q), 32'h0);
      @(negedge clk); check("R10 after one edge", 32'(line_q), 32'h0200);

      // R6: value 16 disconnects, value 15 reaches the top line
      wr(2'd1, 8'd16);
      tick(); check("R6 byte 16 off", 32'(line_q), 32'h0);
      wr(2'd1, 8'd15);
      tick(); check("R6 byte 15", 32'(line_q), 32'h8000);

      // R8: reset again while active
      @(negedge clk); rst_n = 1'b0; #1;
      check("R8 reset clears lines", 32'(line_q), 32'h0);
      cfg_sel = 2'd1; #1;
      check("R8 reset restores byte", 32'(cfg_rdata), 32'h80);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule